// File: doc/BRIEF.md
# Dual-Clock FIFO with Retransmit

This block is a first-in first-out buffer whose write port and read port run on unrelated clocks. The write pointer and the read pointer cross between the two domains as Gray codes through two-flop synchronizers. The full and programmable almost-full flags are computed in the write domain. The empty indication, half-full and programmable almost-empty flags are computed in the read domain.

Two strap inputs set the read behaviour. They may change only while reset is asserted. The first strap picks the output mode:
- In standard mode, each word needs a read request.
- In first-word-fall-through mode, the oldest word is presented on the output without a request, and a request removes it.

A retransmit request, sampled on the read clock, rewinds the read side to RAM location 0 so the stored data can be read again. The second strap picks the retransmit latency:
- With normal latency, the empty indication is held for a short setup period before reads resume.
- With zero latency, word 0 is loaded into the output register on the same edge that took the request.

Retransmit is meaningful only while no more than `DEPTH` words have been written since reset.

Top module: `fifo_rt`

## Requirements
- R1: During and after reset, before any write: `rd_empty_o`=1, `full_o`=0, `hf_o`=0, `pae_o`=1, `paf_o`=0.
- R2: Words leave the FIFO in the order they were accepted, under any mix of concurrent writes and reads.
- R3: With `fwft_i`=0 (standard mode), `rdata_o` changes only on a read-clock edge where `ren_i`=1 and `rd_empty_o` was 0. It then shows the next stored word. `rd_empty_o`=1 exactly when no unread word is in RAM.
- R4: With `fwft_i`=1 (fall-through mode), the oldest word appears on `rdata_o` with `rd_empty_o`=0 and no `ren_i`. An edge with `ren_i`=1 removes it.
- R5: The FIFO accepts a write when `wen_i`=1 and `full_o`=0 at the write edge. Writes while `full_o`=1 are dropped. `full_o`=1 when `DEPTH` words are in RAM. In fall-through mode, the word held in the output register is not counted toward this.
- R6: A read request while `rd_empty_o`=1 leaves `rdata_o` and the read position unchanged.
- R7: A read edge with `rt_i`=1 rewinds reading to RAM location 0, so the data since reset is read again from word 0. The write position is not changed.
- R8: With `rt_zero_i`=0 (normal latency), `rd_empty_o` is 1 for the two read edges after the retransmit edge. Read requests in that window are ignored. After it, standard mode needs `ren_i` even for word 0, while fall-through mode presents word 0 unrequested.
- R9: With `rt_zero_i`=1 (zero latency), word 0 is on `rdata_o` right after the retransmit edge. In fall-through mode `rd_empty_o` is 0 at once. In standard mode, word 0 counts as read, and the next request yields word 1.
- R10: `hf_o`=1 when the stored count exceeds `DEPTH/2`. It is combinational from read-domain state, so it follows the retransmit edge itself. In fall-through mode the stored count includes the output word.
- R11: `pae_o`=1 when the stored count is at most `PAE_OFS`. It is registered, so after a retransmit it shows the new count from the second read edge, counting the retransmit edge as the first.
- R12: `paf_o`=1 when the count in RAM is at least `DEPTH-PAF_OFS`. After a retransmit it, like `full_o`, follows the rewound read position once that position has crossed the write-clock synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| fwft_i | input | 1 | Strap: 1 = fall-through mode, 0 = standard mode |
| rt_zero_i | input | 1 | Strap: 1 = zero-latency retransmit, 0 = normal |
| wen_i | input | 1 | Write request |
| wdata_i | input | DW | Write data |
| ren_i | input | 1 | Read request |
| rt_i | input | 1 | Retransmit request, read-clock synchronous |
| rdata_o | output | DW | Output register |
| rd_empty_o | output | 1 | Standard: RAM empty; fall-through: no word on output |
| full_o | output | 1 | RAM full |
| hf_o | output | 1 | More than half full |
| pae_o | output | 1 | Programmable almost empty |
| paf_o | output | 1 | Programmable almost full |

## Verification
A read pointer that fails to rewind, or that lands one word off, shows on `rdata_o` on the first read after the retransmit. A corrupt setup counter shows as `rd_empty_o` being low during one of the two setup edges, or as a word being taken during the setup window. A wrong occupancy on either side changes `full_o`, `paf_o`, `hf_o` or `pae_o` within a few edges of both clocks, and the bench compares each flag against the count it keeps itself. Dropped or duplicated words during overflow or underflow surface at the next data comparison.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
  typedef enum logic {MODE_STD = 1'b0, MODE_FWFT = 1'b1} rd_mode_e;
  typedef enum logic {RT_NORMAL = 1'b0, RT_ZERO = 1'b1} rt_lat_e;
endpackage

// File: rtl/fifo_rt_mem.sv
module fifo_rt_mem #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fifo_rt_cdc.sv
module fifo_rt_cdc #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_g2b
    assign bin_o[i] = ^s2_q[W-1:i];
  end
endmodule

// File: rtl/fifo_rt_wr.sv
module fifo_rt_wr #(
  parameter int DEPTH   = 16,
  parameter int PAF_OFS = 2,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = AW + 1
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          wen_i,
  input  logic [PW-1:0] rptr_bin_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [PW-1:0] wgray_o,
  output logic          full_o,
  output logic          paf_o
);
  logic [PW-1:0] wptr_q, wptr_d, wgray_q, occ;

  assign occ     = wptr_q - rptr_bin_i;
  assign full_o  = (occ == PW'(DEPTH));
  assign paf_o   = (occ >= PW'(DEPTH - PAF_OFS));
  assign we_o    = wen_i && !full_o;
  assign wptr_d  = we_o ? wptr_q + PW'(1) : wptr_q;
  assign waddr_o = wptr_q[AW-1:0];
  assign wgray_o = wgray_q;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      wgray_q <= '0;
    end else begin
      wptr_q  <= wptr_d;
      wgray_q <= wptr_d ^ (wptr_d >> 1);
    end
  end

  // R5
  a_r5_no_overflow: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wen_i && full_o) |=> $stable(wptr_q));
  a_r5_occ_bound: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    occ <= PW'(DEPTH));
endmodule

// File: rtl/fifo_rt_rd.sv
module fifo_rt_rd
  import fifo_rt_pkg::*;
#(
  parameter int DW       = 32,
  parameter int DEPTH    = 16,
  parameter int PAE_OFS  = 2,
  parameter int RT_SETUP = 2,
  localparam int AW      = $clog2(DEPTH),
  localparam int PW      = AW + 1,
  localparam int CW      = $clog2(RT_SETUP + 1)
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  rd_mode_e      mode_i,
  input  rt_lat_e       lat_i,
  input  logic          ren_i,
  input  logic          rt_i,
  input  logic [PW-1:0] wptr_bin_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [PW-1:0] rgray_o,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          hf_o,
  output logic          pae_o
);
  logic [PW-1:0] rptr_q, rptr_d, rgray_q, occ;
  logic [DW-1:0] dout_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          valid_q, valid_d, pae_q, load;
  logic          fwft, zero, busy, mem_empty;

  assign fwft      = (mode_i == MODE_FWFT);
  assign zero      = (lat_i == RT_ZERO);
  assign busy      = (cnt_q != '0);
  assign mem_empty = (rptr_q == wptr_bin_i);
  assign raddr_o   = rt_i ? '0 : rptr_q[AW-1:0];

  always_comb begin
    rptr_d  = rptr_q;
    valid_d = valid_q;
    cnt_d   = cnt_q;
    load    = 1'b0;
    if (rt_i) begin
      if (zero && wptr_bin_i != '0) begin
        load    = 1'b1;
        rptr_d  = PW'(1);
        valid_d = 1'b1;
        cnt_d   = '0;
      end else begin
        rptr_d  = '0;
        valid_d = 1'b0;
        cnt_d   = zero ? '0 : CW'(RT_SETUP);
      end
    end else if (busy) begin
      cnt_d = cnt_q - CW'(1);
    end else if (fwft) begin
      if (!valid_q || ren_i) begin
        if (!mem_empty) begin
          load    = 1'b1;
          rptr_d  = rptr_q + PW'(1);
          valid_d = 1'b1;
        end else begin
          valid_d = 1'b0;
        end
      end
    end else if (ren_i && !mem_empty) begin
      load   = 1'b1;
      rptr_d = rptr_q + PW'(1);
    end
  end

  // stored count as seen by the reader: RAM words plus the fall-through word
  assign occ     = (wptr_bin_i - rptr_q) + PW'(fwft && valid_q);
  assign empty_o = busy || (fwft ? !valid_q : mem_empty);
  assign hf_o    = (occ > PW'(DEPTH / 2));
  assign pae_o   = pae_q;
  assign rdata_o = dout_q;
  assign rgray_o = rgray_q;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      rgray_q <= '0;
      dout_q  <= '0;
      valid_q <= 1'b0;
      cnt_q   <= '0;
      pae_q   <= 1'b1;
    end else begin
      rptr_q  <= rptr_d;
      rgray_q <= rptr_d ^ (rptr_d >> 1);
      valid_q <= valid_d;
      cnt_q   <= cnt_d;
      pae_q   <= (occ <= PW'(PAE_OFS));
      if (load) dout_q <= mem_rdata_i;
    end
  end

  // R6
  a_r6_empty_read_ignored: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!rt_i && !fwft && ren_i && empty_o) |=> ($stable(rptr_q) && $stable(rdata_o)));
  // R7
  a_r7_rewind: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rt_i |=> (rptr_q[PW-1:1] == '0));
  // R8
  a_r8_setup_empty: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rt_i && !zero) |=> empty_o);
  a_r8_setup_hold: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (busy && !rt_i) |=> $stable(rptr_q));
  // R9
  a_r9_zero_fwft: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rt_i && zero && fwft && wptr_bin_i != '0) |=> !empty_o);
  // R4
  a_r4_fall_through: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (fwft && !rt_i && !busy && !valid_q && !mem_empty) |=> !empty_o);
endmodule

// File: rtl/fifo_rt.sv
module fifo_rt
  import fifo_rt_pkg::*;
#(
  parameter int DW       = 32,
  parameter int DEPTH    = 16,
  parameter int PAE_OFS  = 2,
  parameter int PAF_OFS  = 2,
  parameter int RT_SETUP = 2
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic          rt_zero_i,
  input  logic          wen_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ren_i,
  input  logic          rt_i,
  output logic [DW-1:0] rdata_o,
  output logic          rd_empty_o,
  output logic          full_o,
  output logic          hf_o,
  output logic          pae_o,
  output logic          paf_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wptr_r, rptr_w;
  logic [DW-1:0] mem_rdata;

  fifo_rt_wr #(.DEPTH(DEPTH), .PAF_OFS(PAF_OFS)) u_wr (
    .wclk_i, .rst_ni, .wen_i,
    .rptr_bin_i(rptr_w), .we_o(we), .waddr_o(waddr), .wgray_o(wgray),
    .full_o, .paf_o
  );

  fifo_rt_cdc #(.W(PW)) u_w2r (.clk_i(rclk_i), .rst_ni, .gray_i(wgray), .bin_o(wptr_r));
  fifo_rt_cdc #(.W(PW)) u_r2w (.clk_i(wclk_i), .rst_ni, .gray_i(rgray), .bin_o(rptr_w));

  fifo_rt_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .wclk_i, .we_i(we), .waddr_i(waddr), .wdata_i,
    .raddr_i(raddr), .rdata_o(mem_rdata)
  );

  fifo_rt_rd #(.DW(DW), .DEPTH(DEPTH), .PAE_OFS(PAE_OFS), .RT_SETUP(RT_SETUP)) u_rd (
    .rclk_i, .rst_ni,
    .mode_i(rd_mode_e'(fwft_i)), .lat_i(rt_lat_e'(rt_zero_i)),
    .ren_i, .rt_i, .wptr_bin_i(wptr_r), .mem_rdata_i(mem_rdata),
    .raddr_o(raddr), .rgray_o(rgray), .rdata_o,
    .empty_o(rd_empty_o), .hf_o, .pae_o
  );
endmodule

// File: tb/fifo_rt_tb_top.sv
module fifo_rt_tb_top;
  localparam int DW = 32, DEPTH = 16, PAE = 2, PAF = 2;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic fwft = 1'b0, zero = 1'b0, wen = 1'b0, ren = 1'b0, rt = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rd_empty, full, hf, pae, paf;

  always #5 wclk = ~wclk;
  always #7 rclk = ~rclk;

  fifo_rt #(.DW(DW), .DEPTH(DEPTH), .PAE_OFS(PAE), .PAF_OFS(PAF)) dut_i (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .fwft_i(fwft), .rt_zero_i(zero),
    .wen_i(wen), .wdata_i(wdata), .ren_i(ren), .rt_i(rt),
    .rdata_o(rdata), .rd_empty_o(rd_empty), .full_o(full), .hf_o(hf),
    .pae_o(pae), .paf_o(paf)
  );

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] hist [0:1023];
  int wr_n = 0, rd_idx = 0;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s fwft=%0b zero=%0b actual=%0h expected=%0h t=%0t", req, fwft, zero, act, exp, $time);
    end
  endtask

  function automatic int stored();
    return wr_n - rd_idx;
  endfunction

  function automatic int occ_w();
    int s = wr_n - rd_idx;
    return (fwft && s > 0) ? s - 1 : s;
  endfunction

  task automatic do_reset(input logic f, input logic z);
    @(negedge wclk);
    rst_n = 1'b0; wen = 1'b0; ren = 1'b0; rt = 1'b0; fwft = f; zero = z;
    wr_n = 0; rd_idx = 0;
    #40;
    @(negedge wclk) rst_n = 1'b1;
  endtask

  task automatic quiesce();
    repeat (8) @(negedge rclk);
  endtask

  task automatic check_flags();
    quiesce();
    chk("R10", 32'(hf), 32'(stored() > DEPTH / 2));
    chk("R11", 32'(pae), 32'(stored() <= PAE));
    chk("R12", 32'(paf), 32'(occ_w() >= DEPTH - PAF));
    chk("R5", 32'(full), 32'(occ_w() == DEPTH));
    chk(fwft ? "R4" : "R3", 32'(rd_empty), 32'(stored() == 0));
  endtask

  task automatic wr_word(input logic [DW-1:0] d);
    @(negedge wclk);
    if (!full) begin
      wen = 1'b1; wdata = d; hist[wr_n] = d; wr_n++;
    end
    @(negedge wclk) wen = 1'b0;
  endtask

  task automatic rd_word(input string req);
    @(negedge rclk);
    while (rd_empty) @(negedge rclk);
    if (fwft) begin
      chk(req, rdata, hist[rd_idx]);
      ren = 1'b1;
      @(negedge rclk) ren = 1'b0;
    end else begin
      ren = 1'b1;
      @(negedge rclk) ren = 1'b0;
      chk(req, rdata, hist[rd_idx]);
    end
    rd_idx++;
  endtask

  task automatic run_cfg(input logic f, input logic z);
    logic [DW-1:0] d0;
    // R1 reset state
    do_reset(f, z);
    @(negedge rclk);
    chk("R1", 32'(rd_empty), 32'd1);
    chk("R1", 32'(full), 32'd0);
    chk("R1", 32'(hf), 32'd0);
    chk("R1", 32'(pae), 32'd1);
    chk("R1", 32'(paf), 32'd0);

    for (int i = 0; i < 15; i++) wr_word($urandom);
    check_flags();
    if (!fwft) begin
      d0 = rdata;
      repeat (3) @(negedge rclk);
      chk("R3", rdata, d0);
    end else begin
      chk("R4", rdata, hist[0]);
    end
    for (int i = 0; i < 13; i++) rd_word("R2");
    check_flags();

    // retransmit
    @(negedge rclk) rt = 1'b1;
    @(negedge rclk) rt = 1'b0;
    chk("R10", 32'(hf), 32'd1);
    chk("R11", 32'(pae), 32'd1);
    if (!zero) begin
      chk("R8", 32'(rd_empty), 32'd1);
      ren = 1'b1;
      @(negedge rclk) ren = 1'b0;
      chk("R8", 32'(rd_empty), 32'd1);
      rd_idx = 0;
    end else begin
      chk("R9", rdata, hist[0]);
      if (fwft) chk("R9", 32'(rd_empty), 32'd0);
      rd_idx = fwft ? 0 : 1;
      @(negedge rclk);
    end
    chk("R11", 32'(pae), 32'd0);
    check_flags();
    while (stored() > 0) rd_word("R7");
    chk(fwft ? "R4" : "R3", 32'(rd_empty), 32'd1);

    // R6 read while empty
    d0 = rdata;
    @(negedge rclk) ren = 1'b1;
    repeat (3) @(negedge rclk);
    ren = 1'b0;
    chk("R6", rdata, d0);
    chk("R6", 32'(rd_empty), 32'd1);
    wr_word(32'hA5A5_0000 + 32'(f) * 2 + 32'(z));
    rd_word("R6");

    // R5 overflow
    do_reset(f, z);
    for (int i = 0; i < DEPTH + 3; i++) begin
      @(negedge wclk);
      d0 = $urandom;
      wen = 1'b1; wdata = d0;
      if (!full) begin hist[wr_n] = d0; wr_n++; end
    end
    @(negedge wclk) wen = 1'b0;
    check_flags();
    while (stored() > 0) rd_word("R5");
    quiesce();
    chk("R5", 32'(rd_empty), 32'd1);

    // R2 random concurrent traffic
    do_reset(f, z);
    fork
      begin
        repeat (300) begin
          @(negedge wclk);
          d0 = $urandom;
          wen = ($urandom % 3) != 0; wdata = d0;
          if (wen && !full) begin hist[wr_n] = d0; wr_n++; end
        end
        @(negedge wclk) wen = 1'b0;
      end
      begin
        logic pend = 1'b0, r;
        repeat (220) begin
          @(negedge rclk);
          if (pend) begin chk("R2", rdata, hist[rd_idx]); rd_idx++; end
          pend = 1'b0;
          r = ($urandom % 2) != 0;
          ren = r;
          if (fwft) begin
            if (r && !rd_empty) begin chk("R2", rdata, hist[rd_idx]); rd_idx++; end
          end else pend = r && !rd_empty;
        end
        @(negedge rclk);
        if (pend) begin chk("R2", rdata, hist[rd_idx]); rd_idx++; end
        ren = 1'b0;
      end
    join
    quiesce();
    while (stored() > 0) rd_word("R2");
    check_flags();
  endtask

  initial begin
    void'($urandom(32'd1977));
    for (int c = 0; c < 4; c++) run_cfg(c[0], c[1]);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule